// File: doc/BRIEF.md
# Load/Store Request Issuing Engine

This block is the requesting end of a non-posted load/store port. A client hands it one command at a time (load or store, an address, and store data for a store). The engine raises the matching request line towards a responder, presents the address with its valid flag and holds both, then follows the responder's busy, address-accept, address-exception and load-valid signals until the access is finished or refused. It then reports back with a single-cycle completion pulse carrying the load data or an error flag.

The command side is a valid/ready handshake. A command is taken on a cycle where both valid and ready are high. Ready is high only while the engine holds no access, the responder's busy is low and abort is low. While ready is low the client must keep its command steady. The completion side has no back-pressure: the done pulse lasts one cycle and the client must take it then. The abort input drops any access in flight without a completion pulse.

Top module: `ldst_requester`

## Requirements
- R1: `cmd_ready_o` is high only when the engine is idle, `pt_busy_i` is low and `abort_i` is low. A request line only rises after a cycle in which `pt_busy_i` was low.
- R2: An accepted command raises exactly one request line: `pt_ld_req_o` when `cmd_store_i` was 0, `pt_st_req_o` when it was 1.
- R3: `pt_addr_vld_o` rises with the request, and `pt_addr_o` carries the command address in that same cycle. Both stay unchanged until the engine has seen `pt_busy_i` low after accept, exception or store completion.
- R4: A one-cycle `pt_addr_exc_i` while the engine waits for the address sends it to idle. In the next cycle `rsp_done_o` and `rsp_err_o` are 1 and both request lines are 0.
- R5: After address accept, a one-cycle `pt_ld_vld_i` is captured. In the next cycle `rsp_done_o` is 1, `rsp_err_o` is 0, `rsp_rdata_o` equals the captured `pt_ld_data_i`, and the request has dropped. A `pt_ld_vld_i` seen before address accept is ignored.
- R6: For a store, `pt_st_vld_o` is high for exactly one cycle, the cycle after `pt_addr_ack_i`, with `pt_st_data_o` equal to the command's store data. It is never high before address accept.
- R7: After the store strobe, the store request and address stay up until `pt_busy_i` is seen low. The cycle after that, `rsp_done_o` is 1 with `rsp_err_o` 0.
- R8: `abort_i` returns the engine to idle at the next edge from any state. All port outputs are then 0 and no completion pulse is produced.
- R9: After synchronous reset, every port output and `rsp_done_o` and `rsp_err_o` are 0, and `port_free_o` is 1.
- R10: `port_free_o` is 1 exactly when the engine holds no access, whatever the state of `pt_busy_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_i | input | 1 | Drop the access in flight |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken |
| cmd_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | ADDR_W | Access address |
| cmd_wdata_i | input | DATA_W | Store data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion was an address exception |
| rsp_rdata_o | output | DATA_W | Load result |
| port_free_o | output | 1 | Engine holds no access |
| pt_ld_req_o | output | 1 | Load request to responder |
| pt_st_req_o | output | 1 | Store request to responder |
| pt_addr_vld_o | output | 1 | Address valid |
| pt_addr_o | output | ADDR_W | Address to responder |
| pt_busy_i | input | 1 | Responder busy |
| pt_addr_ack_i | input | 1 | One-cycle address accept |
| pt_addr_exc_i | input | 1 | One-cycle address exception |
| pt_ld_vld_i | input | 1 | One-cycle load data valid |
| pt_ld_data_i | input | DATA_W | Load data |
| pt_st_vld_o | output | 1 | One-cycle store strobe |
| pt_st_data_o | output | DATA_W | Store data |

## Verification
The hardest case to reach from the ports is a stray load-valid pulse that arrives while the engine still waits for address acceptance. The engine must ignore it and then accept the real one later. A second hard case is the store's trailing wait, where busy stays high for extra cycles after the strobe. The bench acts as the responder, cycle by cycle, and places these pulses in exact cycles. It injects the stray pulse with junk data and keeps busy high for longer than a real responder would.

// File: rtl/ldst_req_pkg.sv
package ldst_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_ADDR = 3'd1,
    ST_WAIT_LD   = 3'd2,
    ST_SEND_ST   = 3'd3,
    ST_WAIT_FREE = 3'd4
  } req_state_t;
endpackage

// File: rtl/ldst_req_cmd_reg.sv
module ldst_req_cmd_reg #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              store_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              store_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      store_q <= store_in;
      addr_q  <= addr_in;
      wdata_q <= wdata_in;
    end
  end
endmodule

// File: rtl/ldst_req_fsm.sv
module ldst_req_fsm
  import ldst_req_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       cmd_valid,
  input  logic       store_q,
  input  logic       busy,
  input  logic       addr_ack,
  input  logic       addr_exc,
  input  logic       ld_vld,
  output req_state_t state,
  output logic       ready,
  output logic       accept,
  output logic       ld_capture,
  output logic       fin_ok,
  output logic       fin_err
);
  req_state_t nxt;

  assign ready  = (state == ST_IDLE) && !busy && !abort;
  assign accept = ready && cmd_valid;

  always_comb begin
    nxt        = state;
    ld_capture = 1'b0;
    fin_ok     = 1'b0;
    fin_err    = 1'b0;
    unique case (state)
      ST_IDLE:      if (accept) nxt = ST_WAIT_ADDR;
      ST_WAIT_ADDR: begin
        if (addr_exc) begin
          nxt     = ST_IDLE;
          fin_err = 1'b1;
        end else if (addr_ack) begin
          nxt = store_q ? ST_SEND_ST : ST_WAIT_LD;
        end
      end
      ST_WAIT_LD: begin
        if (ld_vld) begin
          nxt        = ST_IDLE;
          ld_capture = 1'b1;
          fin_ok     = 1'b1;
        end
      end
      ST_SEND_ST:   nxt = ST_WAIT_FREE;
      ST_WAIT_FREE: begin
        if (!busy) begin
          nxt    = ST_IDLE;
          fin_ok = 1'b1;
        end
      end
      default:      nxt = ST_IDLE;
    endcase
    if (abort) begin
      nxt        = ST_IDLE;
      ld_capture = 1'b0;
      fin_ok     = 1'b0;
      fin_err    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // R1
  issue_after_free_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_ADDR && $past(state) == ST_IDLE) |-> $past(!busy));

  // R4
  exc_reports_err_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_ADDR && addr_exc && !abort) |=> (state == ST_IDLE));

  // R6
  strobe_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEND_ST) |-> $past(addr_ack));

  // R8
  abort_idles_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state == ST_IDLE));
endmodule

// File: rtl/ldst_req_result.sv
module ldst_req_result #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_capture,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              fin_ok,
  input  logic              fin_err,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      done <= fin_ok || fin_err;
      err  <= fin_err;
      if (ld_capture) rdata <= ld_data;
    end
  end

  // R4
  err_only_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R5
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/ldst_requester.sv
module ldst_requester #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_store_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  output logic              rsp_done_o,
  output logic              rsp_err_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              port_free_o,
  output logic              pt_ld_req_o,
  output logic              pt_st_req_o,
  output logic              pt_addr_vld_o,
  output logic [ADDR_W-1:0] pt_addr_o,
  input  logic              pt_busy_i,
  input  logic              pt_addr_ack_i,
  input  logic              pt_addr_exc_i,
  input  logic              pt_ld_vld_i,
  input  logic [DATA_W-1:0] pt_ld_data_i,
  output logic              pt_st_vld_o,
  output logic [DATA_W-1:0] pt_st_data_o
);
  import ldst_req_pkg::*;

  req_state_t        state;
  logic              accept, ld_capture, fin_ok, fin_err;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              active, strobe;

  ldst_req_cmd_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .take(accept),
    .store_in(cmd_store_i), .addr_in(cmd_addr_i), .wdata_in(cmd_wdata_i),
    .store_q(store_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  ldst_req_fsm u_fsm (
    .clk(clk), .rst(rst), .abort(abort_i), .cmd_valid(cmd_valid_i),
    .store_q(store_q), .busy(pt_busy_i), .addr_ack(pt_addr_ack_i),
    .addr_exc(pt_addr_exc_i), .ld_vld(pt_ld_vld_i),
    .state(state), .ready(cmd_ready_o), .accept(accept),
    .ld_capture(ld_capture), .fin_ok(fin_ok), .fin_err(fin_err)
  );

  ldst_req_result #(.DATA_W(DATA_W)) u_res (
    .clk(clk), .rst(rst), .ld_capture(ld_capture), .ld_data(pt_ld_data_i),
    .fin_ok(fin_ok), .fin_err(fin_err),
    .done(rsp_done_o), .err(rsp_err_o), .rdata(rsp_rdata_o)
  );

  assign active        = (state != ST_IDLE);
  assign strobe        = (state == ST_SEND_ST);
  assign port_free_o   = !active;
  assign pt_ld_req_o   = active && !store_q;
  assign pt_st_req_o   = active && store_q;
  assign pt_addr_vld_o = active;
  assign pt_addr_o     = active ? addr_q : '0;
  assign pt_st_vld_o   = strobe;
  assign pt_st_data_o  = strobe ? wdata_q : '0;

  // R2
  one_req_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pt_ld_req_o, pt_st_req_o}));

  // R3
  addr_held_chk: assert property (@(posedge clk) disable iff (rst)
    (pt_addr_vld_o && $past(pt_addr_vld_o) && !$past(abort_i)) |-> $stable(pt_addr_o));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    pt_st_vld_o |=> !pt_st_vld_o);

  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!pt_addr_vld_o && !rsp_done_o));
endmodule

// File: tb/sim_ldst_requester.sv
module sim_ldst_requester;
  localparam int DW = 64;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abort_i = 0, cmd_valid_i = 0, cmd_store_i = 0;
  logic [AW-1:0] cmd_addr_i = '0;
  logic [DW-1:0] cmd_wdata_i = '0;
  logic cmd_ready_o, rsp_done_o, rsp_err_o, port_free_o;
  logic [DW-1:0] rsp_rdata_o;
  logic pt_ld_req_o, pt_st_req_o, pt_addr_vld_o, pt_st_vld_o;
  logic [AW-1:0] pt_addr_o;
  logic [DW-1:0] pt_st_data_o;
  logic pt_busy_i = 0, pt_addr_ack_i = 0, pt_addr_exc_i = 0, pt_ld_vld_i = 0;
  logic [DW-1:0] pt_ld_data_i = '0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ldst_requester #(.DATA_W(DW), .ADDR_W(AW)) u0 (.*);

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid_i = 1; cmd_store_i = st; cmd_addr_i = a; cmd_wdata_i = d;
    #0;
    chk("R1 ready when free", cmd_ready_o, 1);
    tick();
    cmd_valid_i = 0;
    pt_busy_i = 1;
  endtask

  task automatic t_reset();
    chk("R9 ld_req", pt_ld_req_o, 0);
    chk("R9 st_req", pt_st_req_o, 0);
    chk("R9 addr_vld", pt_addr_vld_o, 0);
    chk("R9 st_vld", pt_st_vld_o, 0);
    chk("R9 done", rsp_done_o, 0);
    chk("R9 free", port_free_o, 1);
  endtask

  task automatic t_busy_blocks();
    pt_busy_i = 1; cmd_valid_i = 1; cmd_store_i = 0;
    #0;
    chk("R1 ready low while busy", cmd_ready_o, 0);
    chk("R10 free while busy", port_free_o, 1);
    tick();
    chk("R1 no request while busy", pt_ld_req_o, 0);
    cmd_valid_i = 0; pt_busy_i = 0;
    tick();
  endtask

  task automatic t_load();
    issue(0, 48'h1234_5678_9ABC, '0);
    chk("R2 ld_req", pt_ld_req_o, 1);
    chk("R2 st_req", pt_st_req_o, 0);
    chk("R3 addr_vld", pt_addr_vld_o, 1);
    chk("R3 addr", pt_addr_o, 48'h1234_5678_9ABC);
    chk("R10 free low", port_free_o, 0);
    cmd_valid_i = 1; cmd_store_i = 1;
    #0;
    chk("R1 ready low when active", cmd_ready_o, 0);
    pt_ld_vld_i = 1; pt_ld_data_i = 64'hDEAD;
    tick();
    cmd_valid_i = 0; pt_ld_vld_i = 0;
    chk("R5 early ld_vld ignored", rsp_done_o, 0);
    chk("R5 still requesting", pt_ld_req_o, 1);
    tick();
    chk("R3 addr held", pt_addr_o, 48'h1234_5678_9ABC);
    pt_addr_ack_i = 1;
    tick();
    pt_addr_ack_i = 0;
    chk("R6 no strobe on load", pt_st_vld_o, 0);
    tick(); tick();
    chk("R3 addr held in wait", pt_addr_vld_o, 1);
    pt_ld_vld_i = 1; pt_ld_data_i = 64'h0123_4567_89AB_CDEF; pt_busy_i = 0;
    tick();
    pt_ld_vld_i = 0; pt_ld_data_i = '0;
    chk("R5 done", rsp_done_o, 1);
    chk("R5 err", rsp_err_o, 0);
    chk("R5 rdata", rsp_rdata_o, 64'h0123_4567_89AB_CDEF);
    chk("R5 req dropped", pt_ld_req_o, 0);
    chk("R2 no store side", pt_st_req_o, 0);
    tick();
    chk("R5 done single", rsp_done_o, 0);
  endtask

  task automatic t_store();
    issue(1, 48'h0000_0000_0040, 64'hCAFE_F00D_0BAD_BEEF);
    chk("R2 st_req", pt_st_req_o, 1);
    chk("R2 ld_req", pt_ld_req_o, 0);
    chk("R6 no strobe before ack", pt_st_vld_o, 0);
    tick();
    chk("R6 no strobe before ack 2", pt_st_vld_o, 0);
    pt_addr_ack_i = 1;
    tick();
    pt_addr_ack_i = 0;
    chk("R6 strobe", pt_st_vld_o, 1);
    chk("R6 data", pt_st_data_o, 64'hCAFE_F00D_0BAD_BEEF);
    tick();
    chk("R6 strobe one cycle", pt_st_vld_o, 0);
    chk("R7 req held", pt_st_req_o, 1);
    tick();
    chk("R7 no done while busy", rsp_done_o, 0);
    chk("R3 addr held after strobe", pt_addr_o, 48'h0000_0000_0040);
    pt_busy_i = 0;
    tick();
    chk("R7 done", rsp_done_o, 1);
    chk("R7 err", rsp_err_o, 0);
    chk("R7 req dropped", pt_st_req_o, 0);
    tick();
  endtask

  task automatic t_exc();
    issue(0, 48'hFFFF_0000_0008, '0);
    tick();
    pt_addr_exc_i = 1; pt_busy_i = 0;
    tick();
    pt_addr_exc_i = 0;
    chk("R4 done", rsp_done_o, 1);
    chk("R4 err", rsp_err_o, 1);
    chk("R4 req dropped", pt_ld_req_o, 0);
    chk("R4 addr_vld dropped", pt_addr_vld_o, 0);
    tick();
    chk("R4 err cleared", rsp_err_o, 0);
  endtask

  task automatic t_abort();
    issue(1, 48'h0000_0000_0100, 64'h55);
    pt_addr_ack_i = 1;
    tick();
    pt_addr_ack_i = 0;
    abort_i = 1;
    #0;
    chk("R8 ready low in abort", cmd_ready_o, 0);
    tick();
    abort_i = 0; pt_busy_i = 0;
    chk("R8 st_req low", pt_st_req_o, 0);
    chk("R8 addr_vld low", pt_addr_vld_o, 0);
    chk("R8 strobe low", pt_st_vld_o, 0);
    chk("R8 no done", rsp_done_o, 0);
    chk("R10 free after abort", port_free_o, 1);
    tick();
    chk("R8 still no done", rsp_done_o, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_busy_blocks();
    t_load();
    t_store();
    t_exc();
    t_abort();
    t_load();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule